// File: doc/BRIEF.md
# Cascadable Dual 8-Bit Interval Timer

This block holds two 8-bit interval timers that share one register write port. Each timer has its own enable, its own compare value and its own count-clock enable input. While its enable is set, a timer counts the cycles on which its tick input is high. When the count equals the compare value on a tick, the counter goes back to zero and the timer raises a one-cycle interrupt. The interrupt period is therefore N+1 ticks.

A chain bit in the upper timer's control register joins the two timers into one 16-bit interval timer. In that mode the lower timer's tick drives a 16-bit counter, and the two compare registers together form the 16-bit limit, with the upper register as the high byte. All interrupts come from the lower timer. The upper tick input and the upper interrupt are not used. Software writes the compare values, sets the upper enable and then sets the lower enable. To stop the chained timer it clears the lower enable.

Top module: `cascade_ival_timer`

## Requirements
- R1: A synchronous active-high reset clears both enables, the chain bit, both compare registers and both counters, and drives both interrupts low.
- R2: On a write, address 0 is the lower control register, 1 the lower compare, 2 the upper control and 3 the upper compare. Bit 0 of a control register is that timer's enable. Bit 1 of the upper control register selects chained 16-bit mode.
- R3: With chaining off, each timer is an independent 8-bit clear-on-match timer. Its interrupt goes high for one cycle in the cycle after the tick on which its count equals its compare value N, which gives a period of N+1 ticks.
- R4: A counter advances only on cycles where its own tick input is high. On all other cycles it holds.
- R5: Clearing a timer's enable resets its counter to zero. After it is enabled again, the first interrupt follows N+1 ticks.
- R6: In chained mode the limit is {upper compare, lower compare}. The lower interrupt repeats every N+1 lower ticks for any N from 0000h to FFFFh.
- R7: In chained mode the upper tick input has no effect.
- R8: In chained mode counting needs both enables set. With only the lower enable set, no interrupt ever occurs. Clearing the lower enable stops the count and resets all 16 bits to zero.
- R9: In chained mode the upper interrupt stays low.
- R10: The compare value is captured while the timer is stopped and held while it runs. A compare write made during a run takes effect only at the next start.
- R11: An interrupt is raised only in the cycle after a tick of the timer that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0..3) |
| wr_data | input | 8 | Write data |
| tick_lo | input | 1 | Count-clock enable, lower timer (also drives chained mode) |
| tick_hi | input | 1 | Count-clock enable, upper timer |
| irq_lo | output | 1 | Lower interrupt pulse |
| irq_hi | output | 1 | Upper interrupt pulse |

## Verification
The bench runs a limit of 0000h in chained mode, where a design that mishandles the clear-and-count step would either miss pulses or stretch the period to two ticks. It also runs the full FFFFh limit, where a counter with a weak carry from the low byte into the high byte would wrap early or never match. It enables the lower timer alone with chaining on, which a design that gates only on the lower enable would start counting. It writes a new compare value in the middle of a run, which a design without a held copy of the limit would apply at once and so shift the period. It also toggles the upper tick and checks the upper interrupt in chained mode, where leakage from the upper timer would show up as spurious or shifted pulses.

// File: rtl/cit_pkg.sv
package cit_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_LO_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_LO_CMP  = 2'd1;
  localparam logic [ADDR_W-1:0] A_HI_CTRL = 2'd2;
  localparam logic [ADDR_W-1:0] A_HI_CMP  = 2'd3;
  localparam int EN_BIT   = 0;
  localparam int CHAIN_BIT = 1;
  localparam int NUM_CH   = 2;
endpackage

// File: rtl/cit_regs.sv
module cit_regs
  import cit_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [W-1:0]             wr_data,
  output logic [NUM_CH-1:0]        en,
  output logic [NUM_CH-1:0][W-1:0] cmp,
  output logic                     chain
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam logic [ADDR_W-1:0] CTRL_A = (ch == 0) ? A_LO_CTRL : A_HI_CTRL;
    localparam logic [ADDR_W-1:0] CMP_A  = (ch == 0) ? A_LO_CMP  : A_HI_CMP;
    logic         en_r;
    logic [W-1:0] cmp_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        en_r  <= 1'b0;
        cmp_r <= '0;
      end else if (wr_en) begin
        if (wr_addr == CTRL_A) en_r  <= wr_data[EN_BIT];
        if (wr_addr == CMP_A)  cmp_r <= wr_data;
      end
    end

    assign en[ch]  = en_r;
    assign cmp[ch] = cmp_r;
  end

  always_ff @(posedge clk) begin
    if (rst)                                chain <= 1'b0;
    else if (wr_en && wr_addr == A_HI_CTRL) chain <= wr_data[CHAIN_BIT];
  end
endmodule

// File: rtl/cit_counter.sv
module cit_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cit_hold.sv
module cit_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst)       dout <= '0;
    else if (load) dout <= din;
  end
endmodule

// File: rtl/cascade_ival_timer.sv
module cascade_ival_timer
  import cit_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             tick_lo,
  input  logic             tick_hi,
  output logic             irq_lo,
  output logic             irq_hi
);
  localparam int WIDE_W = 2 * CNT_W;

  function automatic logic at_limit(input logic [WIDE_W-1:0] c,
                                    input logic [WIDE_W-1:0] lim);
    return c == lim;
  endfunction

  function automatic logic low_carry(input logic [CNT_W-1:0] c);
    return &c;
  endfunction

  logic [NUM_CH-1:0]            en;
  logic [NUM_CH-1:0][CNT_W-1:0] cmp;
  logic                         chain_mode;

  cit_regs #(.W(CNT_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .en(en), .cmp(cmp), .chain(chain_mode)
  );

  // Named run and event wires.
  logic run_lo, run_hi;
  logic load_lo, load_hi;
  logic [CNT_W-1:0] cnt_lo, cnt_hi, hold_lo, hold_hi;
  logic match_lo, match_hi;
  logic step_lo, step_hi;
  logic wrap_lo, wrap_hi;
  logic clr_lo, clr_hi;

  assign run_lo  = en[0] & (~chain_mode | en[1]);
  assign run_hi  = en[1] & ~chain_mode;
  assign load_lo = ~run_lo;
  assign load_hi = chain_mode ? ~run_lo : ~run_hi;

  cit_hold #(.W(CNT_W)) hold_lo_i (
    .clk(clk), .rst(rst), .load(load_lo), .din(cmp[0]), .dout(hold_lo)
  );
  cit_hold #(.W(CNT_W)) hold_hi_i (
    .clk(clk), .rst(rst), .load(load_hi), .din(cmp[1]), .dout(hold_hi)
  );

  assign match_lo = chain_mode ? at_limit({cnt_hi, cnt_lo}, {hold_hi, hold_lo})
                               : (cnt_lo == hold_lo);
  assign match_hi = (cnt_hi == hold_hi);

  assign step_lo = tick_lo & run_lo;
  assign wrap_lo = step_lo & match_lo;
  assign clr_lo  = ~run_lo | wrap_lo;

  assign wrap_hi = tick_hi & run_hi & match_hi;
  assign step_hi = chain_mode ? (step_lo & low_carry(cnt_lo)) : (tick_hi & run_hi);
  assign clr_hi  = chain_mode ? clr_lo : (~run_hi | wrap_hi);

  cit_counter #(.W(CNT_W)) cnt_lo_i (
    .clk(clk), .rst(rst), .clr(clr_lo), .inc(step_lo), .cnt(cnt_lo)
  );
  cit_counter #(.W(CNT_W)) cnt_hi_i (
    .clk(clk), .rst(rst), .clr(clr_hi), .inc(step_hi), .cnt(cnt_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_lo <= 1'b0;
      irq_hi <= 1'b0;
    end else begin
      irq_lo <= wrap_lo;
      irq_hi <= wrap_hi;
    end
  end
endmodule

// File: rtl/cit_checker.sv
module cit_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         tick_lo,
  input logic         tick_hi,
  input logic         irq_lo,
  input logic         irq_hi,
  input logic         chain_mode,
  input logic         run_lo,
  input logic         run_hi,
  input logic [W-1:0] cnt_lo,
  input logic [W-1:0] cnt_hi,
  input logic [W-1:0] hold_lo,
  input logic [W-1:0] hold_hi
);
  AST_IRQ_LO_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    irq_lo |-> $past(tick_lo)); // R11
  AST_IRQ_HI_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    irq_hi |-> $past(tick_hi)); // R11
  AST_UPPER_QUIET: assert property (@(posedge clk) disable iff (rst)
    irq_hi |-> !$past(chain_mode)); // R9
  AST_IDLE_ZERO_LO: assert property (@(posedge clk) disable iff (rst)
    !run_lo |=> (cnt_lo == '0)); // R5
  AST_IDLE_ZERO_HI: assert property (@(posedge clk) disable iff (rst)
    (!run_hi && !chain_mode) |=> (cnt_hi == '0)); // R5
  AST_CHAIN_STOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (chain_mode && !run_lo) |=> (cnt_hi == '0)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (chain_mode && run_lo) |-> ({cnt_hi, cnt_lo} <= {hold_hi, hold_lo})); // R6
  AST_NO_OVERFLOW_LO: assert property (@(posedge clk) disable iff (rst)
    (!chain_mode && run_lo) |-> (cnt_lo <= hold_lo)); // R3
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (run_lo && !tick_lo) |=> $stable(cnt_lo)); // R4
  AST_CMP_HELD: assert property (@(posedge clk) disable iff (rst)
    (run_lo && $past(run_lo)) |-> $stable(hold_lo)); // R10
endmodule

bind cascade_ival_timer cit_checker #(.W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .tick_lo(tick_lo), .tick_hi(tick_hi),
  .irq_lo(irq_lo), .irq_hi(irq_hi), .chain_mode(chain_mode),
  .run_lo(run_lo), .run_hi(run_hi), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
  .hold_lo(hold_lo), .hold_hi(hold_hi)
);

// File: tb/cascade_ival_timer_tb.sv
module cascade_ival_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tick_lo = 1'b0;
  logic       tick_hi = 1'b0;
  logic       irq_lo, irq_hi;

  always #(CLK_PERIOD/2) clk = ~clk;

  cascade_ival_timer #(.CNT_W(8)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tick_lo(tick_lo), .tick_hi(tick_hi), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  typedef struct {
    bit    lo;
    bit    hi;
    string tag;
  } exp_t;

  exp_t  sb_q[$];
  int    n_checks = 0;
  int    n_errors = 0;
  string cur_tag  = "R1";

  // Reference state of the bench model.
  bit m_en0, m_en1, m_chain;
  int m_cmp0, m_cmp1, m_h0, m_h1, m_c0, m_c1;

  task automatic model_step(input bit we, input int a, input int d,
                            input bit tl, input bit th);
    bit run0, run1, e_lo, e_hi;
    int lim, c;
    exp_t item;
    run0 = m_en0 && (!m_chain || m_en1);
    run1 = m_en1 && !m_chain;
    e_lo = 0;
    e_hi = 0;
    if (m_chain) begin
      lim = m_h1 * 256 + m_h0;
      c   = m_c1 * 256 + m_c0;
      if (!run0) c = 0;
      else if (tl) begin
        if (c == lim) begin e_lo = 1; c = 0; end
        else c = c + 1;
      end
      m_c1 = c / 256;
      m_c0 = c % 256;
    end else begin
      if (!run0) m_c0 = 0;
      else if (tl) begin
        if (m_c0 == m_h0) begin e_lo = 1; m_c0 = 0; end
        else m_c0 = m_c0 + 1;
      end
      if (!run1) m_c1 = 0;
      else if (th) begin
        if (m_c1 == m_h1) begin e_hi = 1; m_c1 = 0; end
        else m_c1 = m_c1 + 1;
      end
    end
    if (!run0) m_h0 = m_cmp0;
    if (m_chain ? !run0 : !run1) m_h1 = m_cmp1;
    if (we) begin
      case (a)
        0: m_en0 = d[0];
        1: m_cmp0 = d;
        2: begin m_en1 = d[0]; m_chain = d[1]; end
        default: m_cmp1 = d;
      endcase
    end
    item.lo  = e_lo;
    item.hi  = e_hi;
    item.tag = cur_tag;
    sb_q.push_back(item);
  endtask

  // Driver: one system clock cycle of stimulus plus the expected result.
  task automatic cycle(input bit we, input int a, input int d,
                       input bit tl, input bit th);
    @(negedge clk);
    wr_en   = we;
    wr_addr = a[1:0];
    wr_data = d[7:0];
    tick_lo = tl;
    tick_hi = th;
    model_step(we, a, d, tl, th);
  endtask

  task automatic wr(input int a, input int d);
    cycle(1'b1, a, d, 1'b0, 1'b0);
  endtask

  // Tick every p cycles (p = 0: never).
  task automatic run(input int n, input int plo, input int phi);
    for (int i = 0; i < n; i++) begin
      cycle(1'b0, 0, 0, (plo != 0) && (i % plo == 0), (phi != 0) && (i % phi == 0));
    end
  endtask

  // Monitor: pops each expected item once the design has produced it.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_checks++;
        if (irq_lo !== e.lo || irq_hi !== e.hi) begin
          n_errors++;
          $display("FAIL %s: irq_lo/irq_hi actual %b/%b expected %b/%b at %0t",
                   e.tag, irq_lo, irq_hi, e.lo, e.hi, $time);
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    // R1: reset state with ticks active.
    tick_lo = 1'b1;
    tick_hi = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    n_checks++;
    if (irq_lo !== 1'b0 || irq_hi !== 1'b0) begin
      n_errors++;
      $display("FAIL R1: irq actual %b/%b expected 0/0", irq_lo, irq_hi);
    end
    @(negedge clk);
    rst = 1'b0;
    run(6, 1, 1);  // R1: nothing enabled after reset

    cur_tag = "R3";
    wr(1, 3);
    wr(0, 1);
    run(20, 1, 0);

    cur_tag = "R4";
    run(20, 3, 0);
    run(10, 0, 0);

    cur_tag = "R3/R4";
    wr(3, 5);
    wr(2, 1);
    run(30, 1, 2);

    cur_tag = "R5";
    wr(0, 0);
    run(3, 1, 1);
    wr(0, 1);
    run(12, 1, 1);

    cur_tag = "R10";
    wr(1, 7);
    run(12, 1, 0);
    wr(0, 0);
    wr(0, 1);
    run(20, 1, 0);
    wr(0, 0);
    wr(2, 0);
    run(4, 1, 1);

    cur_tag = "R2/R8";
    wr(1, 2);
    wr(3, 1);
    wr(2, 2);
    wr(0, 1);
    run(300, 1, 1);

    cur_tag = "R6/R7/R9";
    wr(2, 3);
    run(600, 1, 1);

    cur_tag = "R8";
    wr(0, 0);
    run(5, 1, 1);
    wr(0, 1);
    run(600, 2, 1);

    cur_tag = "R6 zero limit";
    wr(0, 0);
    wr(1, 0);
    wr(3, 0);
    wr(0, 1);
    run(10, 1, 1);

    cur_tag = "R6 full limit";
    wr(0, 0);
    wr(1, 255);
    wr(3, 255);
    wr(0, 1);
    run(65545, 1, 0);

    run(3, 0, 0);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule